// File: doc/BRIEF.md
# Outbound Record Sequence Number Generator

This block hands out the 64-bit explicit record sequence number that an outbound datagram-security packet carries. The number is two fields side by side: a 16-bit epoch in the upper bits and a 48-bit per-packet counter in the lower bits. Both fields live in a small security-association state register inside the block. Each packet request reads the present value, presents it on the output with a one-cycle valid pulse, and writes the incremented value back.

A change-cipher-spec event moves to the next epoch and restarts the counter at zero. Two enables control the behaviour independently. With header processing off, the block neither counts nor writes its state, and it passes a host-supplied number through. With sequence checking on, a request that finds the counter at its all-ones value is refused with an error flag instead of wrapping. A load strobe lets the host place a value in the state register. It uses the same 64-bit host input.

Top module: `dtls_seqgen`

## Requirements
- R1: After synchronous reset `seq_o` is 0, `seq_vld_o` is 0 and `seq_err_o` is 0, and the stored epoch and counter are both 0, so the first counted request yields 0.
- R2: With header processing on, each request that is not refused produces `seq_vld_o` high for exactly the one cycle after the request, with `seq_o` holding the stored value. The stored counter then increments by one, so successive requests yield 0, 1, 2.
- R3: `seq_o` carries the epoch in bits [63:48] and the counter in bits [47:0]. A change-cipher-spec event alone adds one to the epoch and sets the counter to 0.
- R4: When a change-cipher-spec event and a request share a cycle, the packet uses the new epoch with counter 0, and the next request yields counter 1 in that epoch.
- R5: With both enables on, a request that finds the counter at 2^48-1 raises `seq_err_o` in the next cycle and gives no valid pulse. The stored epoch and counter stay unchanged, so a repeated request is refused again.
- R6: Once raised, `seq_err_o` stays high until the next request or a cycle with `err_clr_i` high. It reads low in the cycle after either of these, unless that request is itself refused.
- R7: With sequence checking off, `seq_err_o` never rises. A request at counter 2^48-1 is served normally, and the counter wraps to 0 with the epoch unchanged.
- R8: With header processing off, a request presents `host_seq_i` on `seq_o` with a valid pulse. The stored epoch and counter are not changed.
- R9: A cycle with `load_i` high copies `host_seq_i` into the state, with bits [63:48] going to the epoch and bits [47:0] to the counter. A request or change-cipher-spec event in that same cycle is ignored and gives no valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Packet request strobe |
| ccs_i | input | 1 | Change-cipher-spec event strobe |
| hdr_en_i | input | 1 | Header processing enable |
| chk_en_i | input | 1 | Sequence overflow check enable |
| err_clr_i | input | 1 | Clears the held error flag |
| load_i | input | 1 | Loads the state from `host_seq_i` |
| host_seq_i | input | 64 | Host number for bypass and load |
| seq_o | output | 64 | Sequence number for the packet |
| seq_vld_o | output | 1 | One-cycle strobe marking a served request |
| seq_err_o | output | 1 | Overflow error, held until request or clear |

## Verification
The stored epoch and counter have no direct output. A wrong value in either shows up at the ports on the very next counted request, one cycle after that request, as a wrong `seq_o`. A corrupt counter that reaches all-ones too early or too late shows up as a wrong `seq_err_o` in that same cycle. The bench therefore follows every state-changing stimulus, including bypass, load, refusal and epoch change, with a counted request and compares the result. State that a refused or bypassed request must leave untouched is read back the same way.

// File: rtl/dtls_seq_pkg.sv
package dtls_seq_pkg;
    localparam int DEF_EPOCH_W = 16;
    localparam int DEF_CNT_W   = 48;
endpackage

// File: rtl/dtls_seq_advance.sv
module dtls_seq_advance #(
    parameter int EW = dtls_seq_pkg::DEF_EPOCH_W,
    parameter int CW = dtls_seq_pkg::DEF_CNT_W
) (
    input  logic [EW-1:0] epoch_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          ccs_i,
    input  logic          req_i,
    input  logic          hdr_en_i,
    input  logic          chk_en_i,
    output logic [EW-1:0] pkt_epoch_o,
    output logic [CW-1:0] pkt_cnt_o,
    output logic          ovf_o,
    output logic [EW-1:0] nxt_epoch_o,
    output logic [CW-1:0] nxt_cnt_o
);
    logic [EW-1:0] e_d;
    logic [CW-1:0] c_d;
    logic          ovf_d;

    always_comb begin
        // epoch change comes first, so a same-cycle packet sees the new epoch
        e_d   = ccs_i ? epoch_i + EW'(1) : epoch_i;
        c_d   = ccs_i ? '0 : cnt_i;
        ovf_d = req_i & hdr_en_i & chk_en_i & (&c_d);
        pkt_epoch_o = e_d;
        pkt_cnt_o   = c_d;
        ovf_o       = ovf_d;
        nxt_epoch_o = e_d;
        nxt_cnt_o   = (req_i & hdr_en_i & ~ovf_d) ? c_d + CW'(1) : c_d;
    end
endmodule

// File: rtl/dtls_seq_emit.sv
module dtls_seq_emit #(
    parameter int SW = dtls_seq_pkg::DEF_EPOCH_W + dtls_seq_pkg::DEF_CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_i,
    input  logic          hdr_en_i,
    input  logic          ovf_i,
    input  logic          clr_i,
    input  logic [SW-1:0] pkt_seq_i,
    input  logic [SW-1:0] host_seq_i,
    output logic [SW-1:0] seq_o,
    output logic          vld_o,
    output logic          err_o
);
    typedef struct packed {
        logic [SW-1:0] seq;
        logic          vld;
        logic          err;
    } emit_t;

    emit_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = 1'b0;
        if (req_i) begin
            out_d.seq = hdr_en_i ? pkt_seq_i : host_seq_i;
            out_d.vld = ~ovf_i;
            out_d.err = ovf_i;
        end else if (clr_i) begin
            out_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign seq_o = out_q.seq;
    assign vld_o = out_q.vld;
    assign err_o = out_q.err;

    // R6: a raised error is held while nothing releases it
    a_r6_err_hold: assert property (@(posedge clk) disable iff (rst)
        (out_q.err && !req_i && !clr_i) |=> out_q.err);

    // R5: a refused request never also reports a served number
    a_r5_err_excl_vld: assert property (@(posedge clk) disable iff (rst)
        !(vld_o && err_o));

    // R2: the valid strobe only follows a request
    a_r2_vld_after_req: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !vld_o);
endmodule

// File: rtl/dtls_seqgen.sv
module dtls_seqgen #(
    parameter int EPOCH_W = dtls_seq_pkg::DEF_EPOCH_W,
    parameter int CNT_W   = dtls_seq_pkg::DEF_CNT_W,
    localparam int SEQ_W  = EPOCH_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic             ccs_i,
    input  logic             hdr_en_i,
    input  logic             chk_en_i,
    input  logic             err_clr_i,
    input  logic             load_i,
    input  logic [SEQ_W-1:0] host_seq_i,
    output logic [SEQ_W-1:0] seq_o,
    output logic             seq_vld_o,
    output logic             seq_err_o
);
    typedef struct packed {
        logic [EPOCH_W-1:0] epoch;
        logic [CNT_W-1:0]   cnt;
    } sa_state_t;

    sa_state_t st_d, st_q;

    logic               req_eff, ccs_eff, ovf;
    logic [EPOCH_W-1:0] pkt_epoch, nxt_epoch;
    logic [CNT_W-1:0]   pkt_cnt, nxt_cnt;

    // a load owns its cycle; strobes that share it are dropped
    assign req_eff = req_i & ~load_i;
    assign ccs_eff = ccs_i & ~load_i;

    dtls_seq_advance #(.EW(EPOCH_W), .CW(CNT_W)) u_adv (
        .epoch_i     (st_q.epoch),
        .cnt_i       (st_q.cnt),
        .ccs_i       (ccs_eff),
        .req_i       (req_eff),
        .hdr_en_i    (hdr_en_i),
        .chk_en_i    (chk_en_i),
        .pkt_epoch_o (pkt_epoch),
        .pkt_cnt_o   (pkt_cnt),
        .ovf_o       (ovf),
        .nxt_epoch_o (nxt_epoch),
        .nxt_cnt_o   (nxt_cnt)
    );

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.epoch = host_seq_i[SEQ_W-1:CNT_W];
            st_d.cnt   = host_seq_i[CNT_W-1:0];
        end else begin
            st_d.epoch = nxt_epoch;
            st_d.cnt   = nxt_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    dtls_seq_emit #(.SW(SEQ_W)) u_emit (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req_eff),
        .hdr_en_i   (hdr_en_i),
        .ovf_i      (ovf),
        .clr_i      (err_clr_i),
        .pkt_seq_i  ({pkt_epoch, pkt_cnt}),
        .host_seq_i (host_seq_i),
        .seq_o      (seq_o),
        .vld_o      (seq_vld_o),
        .err_o      (seq_err_o)
    );

    // R5: a refused request leaves the stored state as it was
    a_r5_state_kept: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (st_q == $past(st_q)));

    // R7: with checking off no error can follow a request
    a_r7_no_err: assert property (@(posedge clk) disable iff (rst)
        (req_eff && !chk_en_i) |=> !seq_err_o);

    // R8: a bypassed request does not touch the state
    a_r8_bypass_state: assert property (@(posedge clk) disable iff (rst)
        (req_eff && !hdr_en_i && !ccs_eff && !load_i) |=> $stable(st_q));

    // R3: an epoch change alone restarts the counter at zero
    a_r3_ccs_restart: assert property (@(posedge clk) disable iff (rst)
        (ccs_eff && !req_eff) |=> (st_q.cnt == '0));
endmodule

// File: tb/sim_dtls_seqgen.sv
module sim_dtls_seqgen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0, ccs_i = 1'b0, hdr_en_i = 1'b1, chk_en_i = 1'b1;
    logic        err_clr_i = 1'b0, load_i = 1'b0;
    logic [63:0] host_seq_i = '0;
    logic [63:0] seq_o;
    logic        seq_vld_o, seq_err_o;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [47:0] CMAX = 48'hFFFF_FFFF_FFFF;

    always #5 clk = ~clk;

    dtls_seqgen u0 (
        .clk(clk), .rst(rst), .req_i(req_i), .ccs_i(ccs_i),
        .hdr_en_i(hdr_en_i), .chk_en_i(chk_en_i), .err_clr_i(err_clr_i),
        .load_i(load_i), .host_seq_i(host_seq_i),
        .seq_o(seq_o), .seq_vld_o(seq_vld_o), .seq_err_o(seq_err_o)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive one cycle of strobes at a falling edge, release them at the next
    task automatic cyc(input logic r, input logic c, input logic l,
                       input logic cl, input logic [63:0] h);
        req_i = r; ccs_i = c; load_i = l; err_clr_i = cl; host_seq_i = h;
        @(negedge clk);
        req_i = 0; ccs_i = 0; load_i = 0; err_clr_i = 0;
    endtask

    task automatic expect_out(input string tag, input logic [63:0] s,
                              input logic v, input logic e);
        if (v) check({tag, " seq"}, seq_o, s);
        check({tag, " vld"}, {63'd0, seq_vld_o}, {63'd0, v});
        check({tag, " err"}, {63'd0, seq_err_o}, {63'd0, e});
    endtask

    task automatic t_reset;
        check("R1 seq after reset", seq_o, 64'd0);
        expect_out("R1", 64'd0, 1'b0, 1'b0);
    endtask

    task automatic t_count;
        cyc(1, 0, 0, 0, '0); expect_out("R1 first", 64'd0, 1, 0);
        cyc(1, 0, 0, 0, '0); expect_out("R2 second", 64'd1, 1, 0);
        cyc(1, 0, 0, 0, '0); expect_out("R2 third", 64'd2, 1, 0);
        cyc(0, 0, 0, 0, '0); expect_out("R2 idle", 64'd2, 0, 0);
    endtask

    task automatic t_ccs;
        cyc(0, 1, 0, 0, '0); expect_out("R3 ccs idle", 64'd0, 0, 0);
        cyc(1, 0, 0, 0, '0); expect_out("R3 new epoch", {16'd1, 48'd0}, 1, 0);
        cyc(1, 0, 0, 0, '0); expect_out("R3 next", {16'd1, 48'd1}, 1, 0);
    endtask

    task automatic t_ccs_req;
        cyc(1, 1, 0, 0, '0); expect_out("R4 same cycle", {16'd2, 48'd0}, 1, 0);
        cyc(1, 0, 0, 0, '0); expect_out("R4 follow", {16'd2, 48'd1}, 1, 0);
    endtask

    task automatic t_load;
        cyc(1, 1, 1, 0, {16'h00AB, 48'h123}); expect_out("R9 load drops req", 64'd0, 0, 0);
        cyc(1, 0, 0, 0, '0); expect_out("R9 loaded", {16'h00AB, 48'h123}, 1, 0);
    endtask

    task automatic t_overflow;
        cyc(0, 0, 1, 0, {16'd5, CMAX});
        cyc(1, 0, 0, 0, '0); expect_out("R5 refuse", 64'd0, 0, 1);
        cyc(0, 0, 0, 0, '0); expect_out("R6 held", 64'd0, 0, 1);
        cyc(1, 0, 0, 0, '0); expect_out("R5 refuse again", 64'd0, 0, 1);
        cyc(0, 0, 0, 1, '0); expect_out("R6 cleared", 64'd0, 0, 0);
        cyc(1, 0, 0, 0, '0); expect_out("R5 refuse third", 64'd0, 0, 1);
        chk_en_i = 0;
        cyc(1, 0, 0, 0, '0); expect_out("R7 served at max", {16'd5, CMAX}, 1, 0);
        cyc(1, 0, 0, 0, '0); expect_out("R7 wrapped", {16'd5, 48'd0}, 1, 0);
        chk_en_i = 1;
    endtask

    task automatic t_bypass;
        hdr_en_i = 0;
        cyc(1, 0, 0, 0, 64'hDEAD_BEEF_0BAD_F00D);
        expect_out("R8 host value", 64'hDEAD_BEEF_0BAD_F00D, 1, 0);
        cyc(1, 0, 0, 0, 64'h1111_2222_3333_4444);
        expect_out("R8 host value 2", 64'h1111_2222_3333_4444, 1, 0);
        hdr_en_i = 1;
        cyc(1, 0, 0, 0, '0); expect_out("R8 state kept", {16'd5, 48'd1}, 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_count();
        t_ccs();
        t_ccs_req();
        t_load();
        t_overflow();
        t_bypass();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule